// File: doc/BRIEF.md
# FG Digital Phase Comparator

This block compares the timing of the motor's frequency-generator (FG) feedback against a reference tick taken from the crystal clock. A free-running divider inside the block produces one reference tick every `REF_DIV` clocks (8192 by default). For each FG period the block emits one charge-pump style correction. It drives `pump_dn` when the FG edge comes before the tick. It drives `pump_up` when the tick comes before the FG edge. The pulse lasts as many clocks as the two events are apart. When both events land in the same cycle, no pulse is produced.

The strobes feed a loop filter outside this block. That filter also sums in a separate speed-discriminator error, and the pair keeps the motor steady under large load changes. A three-valued level output gives the same information as one code: drive high, drive low, or rest at mid level. Each pulse is capped at half a reference period, so a badly mistuned motor cannot make the comparator slip a whole cycle. Deasserting `enable` (the stop condition) clears the divider, the state and both strobes.

The core is a five-state machine:

- `PC_IDLE` waits for either event.
- `PC_DN_RUN` drives down until the tick arrives.
- `PC_UP_RUN` drives up until the FG event arrives.
- `PC_DN_HOLD` is entered from a capped down pulse. It waits silently for the tick.
- `PC_UP_HOLD` is entered from a capped up pulse. It waits silently for the FG event.

Transitions:

- IDLE→DN_RUN on an FG event alone.
- IDLE→UP_RUN on a tick alone.
- IDLE stays in IDLE when both events arrive together.
- DN_RUN→IDLE on a tick.
- UP_RUN→IDLE on an FG event.
- DN_RUN→DN_HOLD and UP_RUN→UP_HOLD when the cap is reached.
- DN_HOLD→IDLE on a tick.
- UP_HOLD→IDLE on an FG event.
- Any state goes to IDLE while `enable` is low.

Top module: `fg_phase_comparator`

## Requirements
- R1: While `enable` is high, the reference tick repeats every `REF_DIV` clocks. The divider starts from zero when enabled, so the first tick is taken at the `REF_DIV-1`-th clock edge after the edge that first samples `enable` high.
- R2: `fg_in` passes through `SYNC_STAGES` (default 2) synchroniser flops. A rising level first sampled at edge A becomes a phase event acted on at edge A+2. Falling edges create no event.
- R3: When the FG event (edge F) precedes the tick (edge T), `pump_dn` is high from edge F until edge T, which is T−F clocks.
- R4: When the tick (edge T) precedes the FG event (edge F), `pump_up` is high from edge T until edge F, which is F−T clocks.
- R5: An FG event and a tick taken at the same edge produce no pulse on either strobe.
- R6: `pump_up` and `pump_dn` are never high in the same cycle.
- R7: A pulse lasts at most `REF_DIV/2` clocks. After a capped pulse, both strobes stay low until the event that would have ended the pulse, and that event starts no new pulse.
- R8: With FG and reference at the same frequency and a fixed offset, exactly one pulse is produced per FG period.
- R9: `pump_lvl` is 2'b10 while `pump_up` is high, 2'b00 while `pump_dn` is high, and 2'b01 when both are low.
- R10: When `enable` is low, the strobes are low from the next edge, FG edges are ignored, and the divider restarts from zero on re-enable.
- R11: While `rst_n` is low, both strobes are low and `pump_lvl` is 2'b01, without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run (high) / stop (low) |
| fg_in | input | 1 | Raw FG pulse from the comparator stage |
| pump_up | output | 1 | Speed-up charge-pump strobe |
| pump_dn | output | 1 | Slow-down charge-pump strobe |
| pump_lvl | output | 2 | Three-state level: 10 high, 00 low, 01 mid |

## Verification
The hardest case to reach from the ports is the hold states. FG must run at the reference frequency but be offset by more than half a period, and the pairing must stay in step across several periods. The bench builds every FG waveform directly from the tick timeline. It restarts the divider for each run and places the synchronised FG event at a chosen signed offset from each tick, two clocks ahead of the edge where it should act. Offsets just either side of the cap, zero, ±1 and random values then exercise the run, hold and aligned paths. A separate directed sequence drops `enable` mid-pulse, toggles FG while stopped, and re-enables to confirm that the divider restarts.

// File: rtl/fgpc_pkg.sv
`timescale 1ns/1ps
package fgpc_pkg;

    typedef enum logic [2:0] {
        PC_IDLE    = 3'd0,
        PC_DN_RUN  = 3'd1,
        PC_UP_RUN  = 3'd2,
        PC_DN_HOLD = 3'd3,
        PC_UP_HOLD = 3'd4
    } pc_state_e;

    localparam logic [1:0] LVL_HIGH = 2'b10;
    localparam logic [1:0] LVL_MID  = 2'b01;
    localparam logic [1:0] LVL_LOW  = 2'b00;

endpackage

// File: rtl/fgpc_ref_div.sv
`timescale 1ns/1ps
module fgpc_ref_div #(
    parameter int REF_DIV = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic ref_tick
);
    localparam int CNT_W = $clog2(REF_DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REF_DIV - 1);

    logic [CNT_W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign ref_tick = run && (div_q == LAST);

endmodule

// File: rtl/fgpc_edge_sync.sv
`timescale 1ns/1ps
module fgpc_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fg_raw,
    output logic fg_event
);
    logic [SYNC_STAGES-1:0] pipe_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= fg_raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[SYNC_STAGES-2:0], fg_raw};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pipe_q[SYNC_STAGES-1];
    end

    assign fg_event = run && pipe_q[SYNC_STAGES-1] && !prev_q;

endmodule

// File: rtl/fgpc_fsm.sv
`timescale 1ns/1ps
module fgpc_fsm
    import fgpc_pkg::*;
#(
    parameter int REF_DIV = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_tick,
    input  logic fg_event,
    output logic pump_up,
    output logic pump_dn
);
    localparam int CAP   = REF_DIV / 2;
    localparam int CAP_W = $clog2(CAP) + 1;
    localparam logic [CAP_W-1:0] CAP_LAST = CAP_W'(CAP - 1);

    pc_state_e        state_q;
    pc_state_e        state_d;
    logic [CAP_W-1:0] width_q;
    logic             cap_hit;

    assign cap_hit = (width_q == CAP_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PC_IDLE;
        else        state_q <= state_d;
    end

    // pulse width counter, zero outside the run states
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q <= '0;
        end else if (state_d != state_q) begin
            width_q <= '0;
        end else if (state_q == PC_DN_RUN || state_q == PC_UP_RUN) begin
            width_q <= width_q + 1'b1;
        end else begin
            width_q <= '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PC_IDLE: begin
                if (fg_event && ref_tick) state_d = PC_IDLE;
                else if (fg_event)        state_d = PC_DN_RUN;
                else if (ref_tick)        state_d = PC_UP_RUN;
            end
            PC_DN_RUN: begin
                if (ref_tick)     state_d = PC_IDLE;
                else if (cap_hit) state_d = PC_DN_HOLD;
            end
            PC_UP_RUN: begin
                if (fg_event)     state_d = PC_IDLE;
                else if (cap_hit) state_d = PC_UP_HOLD;
            end
            PC_DN_HOLD: begin
                if (ref_tick) state_d = PC_IDLE;
            end
            PC_UP_HOLD: begin
                if (fg_event) state_d = PC_IDLE;
            end
            default: state_d = PC_IDLE;
        endcase
        if (!run) state_d = PC_IDLE;
    end

    // outputs
    always_comb begin
        pump_up = 1'b0;
        pump_dn = 1'b0;
        unique case (state_q)
            PC_DN_RUN: pump_dn = 1'b1;
            PC_UP_RUN: pump_up = 1'b1;
            PC_IDLE, PC_DN_HOLD, PC_UP_HOLD: begin
                pump_up = 1'b0;
                pump_dn = 1'b0;
            end
            default: begin
                pump_up = 1'b0;
                pump_dn = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fgpc_level_enc.sv
`timescale 1ns/1ps
module fgpc_level_enc
    import fgpc_pkg::*;
(
    input  logic       drive_up,
    input  logic       drive_dn,
    output logic [1:0] level
);
    always_comb begin
        unique case ({drive_up, drive_dn})
            2'b10:   level = LVL_HIGH;
            2'b01:   level = LVL_LOW;
            default: level = LVL_MID;
        endcase
    end
endmodule

// File: rtl/fg_phase_comparator.sv
`timescale 1ns/1ps
module fg_phase_comparator #(
    parameter int REF_DIV     = 8192,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       fg_in,
    output logic       pump_up,
    output logic       pump_dn,
    output logic [1:0] pump_lvl
);
    logic ref_tick;
    logic fg_event;

    fgpc_ref_div #(.REF_DIV(REF_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .ref_tick (ref_tick)
    );

    fgpc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .fg_raw   (fg_in),
        .fg_event (fg_event)
    );

    fgpc_fsm #(.REF_DIV(REF_DIV)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (enable),
        .ref_tick (ref_tick),
        .fg_event (fg_event),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn)
    );

    fgpc_level_enc u_lvl (
        .drive_up (pump_up),
        .drive_dn (pump_dn),
        .level    (pump_lvl)
    );

endmodule

// File: rtl/fgpc_chk.sv
`timescale 1ns/1ps
module fgpc_chk #(
    parameter int REF_DIV = 8192
) (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       ref_tick,
    input logic       pump_up,
    input logic       pump_dn,
    input logic [1:0] pump_lvl
);
    localparam int CAP   = REF_DIV / 2;
    localparam int GAP_W = $clog2(REF_DIV) + 1;
    localparam int LEN_W = $clog2(CAP) + 2;

    logic [GAP_W-1:0] gap_q;
    logic [LEN_W-1:0] up_len_q;
    logic [LEN_W-1:0] dn_len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  gap_q <= '0;
        else if (!enable || ref_tick) gap_q <= '0;
        else                         gap_q <= gap_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_len_q <= '0;
            dn_len_q <= '0;
        end else begin
            up_len_q <= pump_up ? up_len_q + 1'b1 : '0;
            dn_len_q <= pump_dn ? dn_len_q + 1'b1 : '0;
        end
    end

    a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |-> (gap_q == GAP_W'(REF_DIV - 1)));

    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    a_r7_up_cap: assert property (@(posedge clk) disable iff (!rst_n)
        pump_up |-> (up_len_q < LEN_W'(CAP)));

    a_r7_dn_cap: assert property (@(posedge clk) disable iff (!rst_n)
        pump_dn |-> (dn_len_q < LEN_W'(CAP)));

    a_r9_level_up: assert property (@(posedge clk) disable iff (!rst_n)
        pump_up |-> (pump_lvl == 2'b10));

    a_r9_level_dn: assert property (@(posedge clk) disable iff (!rst_n)
        pump_dn |-> (pump_lvl == 2'b00));

    a_r9_level_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (!pump_up && !pump_dn) |-> (pump_lvl == 2'b01));

    a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pump_up && !pump_dn));

    a_r4_up_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_up) |-> $past(ref_tick));

endmodule

bind fg_phase_comparator fgpc_chk #(.REF_DIV(REF_DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .ref_tick (ref_tick),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .pump_lvl (pump_lvl)
);

// File: tb/fg_phase_comparator_tb_top.sv
`timescale 1ns/1ps
module fg_phase_comparator_tb_top;
    localparam int N      = 128;
    localparam int CAP    = N / 2;
    localparam int PERIODS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       fg_in = 1'b0;
    logic       pump_up;
    logic       pump_dn;
    logic [1:0] pump_lvl;

    int cyc = 0;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fg_phase_comparator #(.REF_DIV(N), .SYNC_STAGES(2)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .fg_in    (fg_in),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .pump_lvl (pump_lvl)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int min_i(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    // R9 encoding expected from the strobes
    function automatic logic [1:0] exp_lvl(input logic up, input logic dn);
        if (up) return 2'b10;
        if (dn) return 2'b00;
        return 2'b01;
    endfunction

    // FG level wanted at edge e so that events act at A0+2, A0+2+N, ... (R2)
    function automatic logic fg_level(input int e, input int a0);
        if (e < a0) return 1'b0;
        return (((e - a0) % N) < (N / 2));
    endfunction

    task automatic run_phase(input int off);
        int e0, r0, a0, w;
        int up_n, dn_n, up_r, dn_r, first_up, bad;
        logic pu, pd;
        @(negedge clk);
        enable = 1'b0;
        fg_in  = 1'b0;
        repeat (4) @(negedge clk);
        enable = 1'b1;
        e0 = cyc + 1;
        r0 = e0 + N - 1;                                   // R1
        a0 = r0 + off - 2;                                 // R2
        w  = r0 + (PERIODS - 1) * N + ((off > 0) ? min_i(off, CAP) : 0) + 2;
        up_n = 0; dn_n = 0; up_r = 0; dn_r = 0; first_up = -1; bad = 0;
        pu = 1'b0; pd = 1'b0;
        fg_in = fg_level(e0, a0);
        while (cyc <= w) begin
            @(negedge clk);
            if (pump_up) begin
                up_n++;
                if (!pu) up_r++;
                if (first_up < 0) first_up = cyc;
            end
            if (pump_dn) begin
                dn_n++;
                if (!pd) dn_r++;
            end
            if ((pump_up && pump_dn) || pump_lvl != exp_lvl(pump_up, pump_dn)) bad++;
            pu = pump_up;
            pd = pump_dn;
            fg_in = fg_level(cyc + 1, a0);
        end
        if (off < 0) begin
            chk(dn_n == PERIODS * min_i(-off, CAP), "R3/R7", "lead down width total", dn_n, PERIODS * min_i(-off, CAP));
            chk(up_n == 0, "R3", "lead up total", up_n, 0);
            chk(dn_r == PERIODS, "R8", "lead pulses per period", dn_r, PERIODS);
        end else if (off > 0) begin
            chk(up_n == PERIODS * min_i(off, CAP), "R4/R7", "lag up width total", up_n, PERIODS * min_i(off, CAP));
            chk(dn_n == 0, "R4", "lag down total", dn_n, 0);
            chk(up_r == PERIODS, "R8", "lag pulses per period", up_r, PERIODS);
            chk(first_up == r0, "R1", "first tick edge", first_up, r0);
        end else begin
            chk(up_n == 0, "R5", "aligned up total", up_n, 0);
            chk(dn_n == 0, "R5", "aligned down total", dn_n, 0);
        end
        chk(bad == 0, "R6/R9", "overlap or level mismatches", bad, 0);
    endtask

    initial begin
        int e1, first, stray;
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!pump_up && !pump_dn, "R11", "strobes in reset", {pump_up, pump_dn}, 0);
        chk(pump_lvl == 2'b01, "R11", "level in reset", pump_lvl, 1);
        rst_n = 1'b1;

        // directed corners: aligned, +-1, cap boundary, beyond cap
        run_phase(0);
        run_phase(-1);
        run_phase(1);
        run_phase(-CAP);
        run_phase(CAP);
        run_phase(-CAP - 1);
        run_phase(CAP + 1);
        run_phase(-70);
        run_phase(70);
        for (int i = 0; i < 10; i++) begin
            run_phase(int'($urandom_range(140)) - 70);
        end

        // R10: stop during an up pulse
        @(negedge clk);
        enable = 1'b0; fg_in = 1'b0;
        repeat (4) @(negedge clk);
        enable = 1'b1;
        e1 = cyc + 1;
        while (cyc < e1 + N - 1 + 5) @(negedge clk);
        chk(pump_up == 1'b1, "R4", "up pulse open before stop", pump_up, 1);
        enable = 1'b0;
        @(negedge clk);
        chk(!pump_up && !pump_dn && pump_lvl == 2'b01, "R10", "strobes after stop",
            {pump_up, pump_dn, pump_lvl}, 1);
        stray = 0;
        for (int i = 0; i < 300; i++) begin
            fg_in = ((i / 20) % 2) == 1;
            @(negedge clk);
            if (pump_up || pump_dn) stray++;
        end
        chk(stray == 0, "R10", "FG ignored while stopped", stray, 0);
        fg_in = 1'b0;
        repeat (5) @(negedge clk);
        enable = 1'b1;
        e1 = cyc + 1;
        first = -1;
        while (first < 0 && cyc < e1 + 2 * N) begin
            @(negedge clk);
            if (pump_up) first = cyc;
        end
        chk(first == e1 + N - 1, "R10", "divider restarted from zero", first, e1 + N - 1);

        // R11: asynchronous reset during a pulse
        @(negedge clk);
        chk(pump_up == 1'b1, "R4", "pulse open before reset", pump_up, 1);
        rst_n = 1'b0;
        #1;
        chk(!pump_up && !pump_dn && pump_lvl == 2'b01, "R11", "reset clears at once",
            {pump_up, pump_dn, pump_lvl}, 1);
        @(negedge clk);
        rst_n = 1'b1;
        enable = 1'b0;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule